// File: doc/BRIEF.md
# Flash Write-Completion Status Poller

This block runs on the host side of a parallel NOR flash. It confirms that a program or erase operation has finished. The command sequence is issued elsewhere. Once its last write strobe has completed, the host pulses `start_i` with the operation mode, a valid status address, the expected byte and a poll limit. For a program, the valid address is the programmed location. For a sector erase, it is any address inside a sector being erased.

The poller then reads the flash status byte through a simple request/acknowledge read port, over and over. Bit 7 of each read is compared with the expected bit 7. Bit 5 is watched as the error flag. Bit 7 of the status can settle at a different moment from the lower bits. For that reason the poller never trusts a single sample. When the error flag rises, bit 7 is read a second time before a failure is declared. After bit 7 matches, one further read captures the final byte.

The outcome is reported with a one-cycle `done_o` pulse. It comes with a pass/fail flag, a timeout flag and the byte from the last read.

Top module: `flash_status_poller`

## Requirements
- R1: After reset the block is idle: `busy_o`, `rd_req_o` and `done_o` are 0, and no read is requested until a start is accepted.
- R2: A start accepted in idle latches the address, mode, expected byte and poll limit. Every read of that operation presents the latched address on `rd_addr_o`.
- R3: When a read returns a byte whose bit 7 equals the expected bit 7, exactly one further confirming read is issued. The operation then ends with `pass_o`=1, and `result_o` equals the confirming read's byte.
- R4: When bit 7 differs and bit 5 is 0, another status read is issued.
- R5: When bit 7 differs and bit 5 is 1, one more read is made. If its bit 7 matches, R3's confirming read follows and the result is a pass. Otherwise the operation ends with `pass_o`=0, `timeout_o`=0, and `result_o` equals that recheck byte.
- R6: With `mode_i`=1 (erase) the expected bit 7 is 1 whatever `data_i` holds. With `mode_i`=0 (program) it is `data_i[7]`.
- R7: If the number of main-loop reads with bit 7 differing and bit 5 at 0 reaches the latched limit, the operation ends with `pass_o`=0 and `timeout_o`=1. A limit of 0 acts as 1.
- R8: `done_o` is high for exactly one cycle per operation. `busy_o` is 0 in the following cycle.
- R9: A start pulse while `busy_o` is 1 is ignored. The current operation keeps its address and its outcome.
- R10: `rd_req_o` stays high with a stable address until `rd_ack_i` is seen. Each acknowledge consumes exactly one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| mode_i | input | 1 | 0 = program, 1 = erase |
| addr_i | input | AW | Valid status address |
| data_i | input | 8 | Expected byte (program) |
| max_polls_i | input | CW | Main-loop read limit |
| busy_o | output | 1 | Operation in progress |
| rd_req_o | output | 1 | Status read request |
| rd_addr_o | output | AW | Address of the read |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | 8 | Status byte returned |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation succeeded |
| timeout_o | output | 1 | Poll limit reached |
| result_o | output | 8 | Byte from the final read |

## Verification
The hardest paths to reach are the two branches that follow a raised error flag. One is a recheck that now matches. The other is a recheck that still disagrees. A real flash reaches them only through timing races inside the part. The bench uses a scripted status model that returns a chosen byte for each successive read. It can therefore place bit 5 high with bit 7 still wrong, and then choose the next byte freely. The same script makes the confirming read return a byte different from the matching one. This shows that the reported result comes from the later read.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CHECK,
        ST_RECHECK,
        ST_CONFIRM,
        ST_DONE
    } poll_state_e;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_mode_e;

    localparam int POLL_BIT = 7;
    localparam int ERR_BIT  = 5;

    typedef struct packed {
        logic pass;
        logic timeout;
    } verdict_t;

    function automatic logic want_b7(op_mode_e m, logic [7:0] d);
        return (m == OP_ERASE) ? 1'b1 : d[POLL_BIT];
    endfunction

    function automatic logic b7_agrees(logic [7:0] s, logic e);
        return s[POLL_BIT] == e;
    endfunction

endpackage

// File: rtl/fsp_poll_counter.sv
module fsp_poll_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] limit_i,
    input  logic          step_i,
    output logic          last_o
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= CW'(1);
        end else if (load_i) begin
            cnt_q <= '0;
            lim_q <= (limit_i == '0) ? CW'(1) : limit_i;
        end else if (step_i) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign last_o = (cnt_q == lim_q - CW'(1));
endmodule

// File: rtl/fsp_byte_capture.sv
module fsp_byte_capture (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear_i,
    input  logic       take_i,
    input  logic [7:0] data_i,
    output logic [7:0] data_o
);
    always_ff @(posedge clk) begin
        if (rst || clear_i) data_o <= '0;
        else if (take_i)    data_o <= data_i;
    end
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
    import fsp_pkg::*;
#(
    parameter int AW = 20,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          mode_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    data_i,
    input  logic [CW-1:0] max_polls_i,
    output logic          busy_o,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_ack_i,
    input  logic [7:0]    rd_data_i,
    output logic          done_o,
    output logic          pass_o,
    output logic          timeout_o,
    output logic [7:0]    result_o
);
    poll_state_e   state_q, state_d;
    logic [AW-1:0] addr_q;
    logic          exp_q;
    verdict_t      verdict_q, verdict_d;
    logic          accept, take, step, last;
    logic [7:0]    sample;

    assign accept = (state_q == ST_IDLE) && start_i;
    assign take   = rd_req_o && rd_ack_i;

    fsp_poll_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load_i  (accept),
        .limit_i (max_polls_i),
        .step_i  (step),
        .last_o  (last)
    );

    fsp_byte_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .clear_i (accept),
        .take_i  (take),
        .data_i  (rd_data_i),
        .data_o  (sample)
    );

    always_comb begin
        state_d   = state_q;
        verdict_d = verdict_q;
        step      = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start_i) begin
                state_d   = ST_READ;
                verdict_d = '0;
            end
            ST_READ: if (rd_ack_i) state_d = ST_CHECK;
            ST_CHECK: begin
                if (b7_agrees(sample, exp_q)) begin
                    state_d = ST_CONFIRM;
                end else if (sample[ERR_BIT]) begin
                    state_d = ST_RECHECK;
                end else if (last) begin
                    state_d   = ST_DONE;
                    verdict_d = '{pass: 1'b0, timeout: 1'b1};
                end else begin
                    step    = 1'b1;
                    state_d = ST_READ;
                end
            end
            ST_RECHECK: if (rd_ack_i) begin
                if (b7_agrees(rd_data_i, exp_q)) begin
                    state_d = ST_CONFIRM;
                end else begin
                    state_d   = ST_DONE;
                    verdict_d = '{pass: 1'b0, timeout: 1'b0};
                end
            end
            ST_CONFIRM: if (rd_ack_i) begin
                state_d   = ST_DONE;
                verdict_d = '{pass: 1'b1, timeout: 1'b0};
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            verdict_q <= '0;
            addr_q    <= '0;
            exp_q     <= 1'b0;
        end else begin
            state_q   <= state_d;
            verdict_q <= verdict_d;
            if (accept) begin
                addr_q <= addr_i;
                exp_q  <= want_b7(op_mode_e'(mode_i), data_i);
            end
        end
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign rd_req_o  = (state_q == ST_READ) || (state_q == ST_RECHECK) ||
                       (state_q == ST_CONFIRM);
    assign rd_addr_o = addr_q;
    assign done_o    = (state_q == ST_DONE);
    assign pass_o    = verdict_q.pass;
    assign timeout_o = verdict_q.timeout;
    assign result_o  = sample;
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst,
    input logic          busy_o,
    input logic          rd_req_o,
    input logic [AW-1:0] rd_addr_o,
    input logic          rd_ack_i,
    input logic          done_o,
    input logic          pass_o,
    input logic          timeout_o
);
    a_r1_idle_no_req: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !rd_req_o);

    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));

    a_r7_timeout_is_fail: assert property (@(posedge clk) disable iff (rst)
        (done_o && timeout_o) |-> !pass_o);

    a_r9_addr_held: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(rd_addr_o));
endmodule

bind flash_status_poller fsp_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy_o    (busy_o),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_ack_i  (rd_ack_i),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .timeout_o (timeout_o)
);

// File: tb/sim_flash_status_poller.sv
module sim_flash_status_poller;
    localparam int PERIOD = 10;
    localparam int AW = 20;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [7:0]    data_i = '0;
    logic [CW-1:0] max_polls_i = '0;
    logic          busy_o, rd_req_o, done_o, pass_o, timeout_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_ack_i = 1'b0;
    logic [7:0]    rd_data_i = '0;
    logic [7:0]    result_o;

    int checks = 0;
    int errors = 0;

    logic [7:0]    scr [0:15];
    int            nreads = 0;
    int            base = 0;
    int            bad_addr = 0;
    logic [AW-1:0] exp_addr = '0;

    always #(PERIOD/2) clk = ~clk;

    flash_status_poller #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .addr_i(addr_i), .data_i(data_i), .max_polls_i(max_polls_i),
        .busy_o(busy_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .done_o(done_o),
        .pass_o(pass_o), .timeout_o(timeout_o), .result_o(result_o)
    );

    // scripted status model: one byte per successive read, acked a cycle later
    always @(posedge clk) begin
        if (rst) begin
            rd_ack_i <= 1'b0;
        end else if (rd_req_o && !rd_ack_i) begin
            int k;
            k = nreads - base;
            if (k > 15) k = 15;
            rd_ack_i  <= 1'b1;
            rd_data_i <= scr[k];
            nreads    <= nreads + 1;
            if (rd_addr_o != exp_addr) bad_addr <= bad_addr + 1;
        end else begin
            rd_ack_i <= 1'b0;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic m, input logic [AW-1:0] a,
                          input logic [7:0] d, input int lim, input int inject,
                          input int e_pass, input int e_tout, input int e_res,
                          input int e_reads);
        int got_done;
        int bad0;
        got_done = 0;
        bad0 = bad_addr;
        @(negedge clk);
        base = nreads; exp_addr = a;
        mode_i = m; addr_i = a; data_i = d; max_polls_i = CW'(lim);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; addr_i = ~a; data_i = ~d; mode_i = ~m;
        for (int i = 0; i < 400; i++) begin
            if (done_o) begin got_done = 1; break; end
            if (i == inject) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        check(req, "done seen", got_done, 1);
        if (got_done != 0) begin
            check(req, "pass", int'(pass_o), e_pass);
            check(req, "timeout", int'(timeout_o), e_tout);
            check(req, "result", int'(result_o), e_res);
            check(req, "read count", nreads - base, e_reads);
            check("R2", "address of every read", bad_addr - bad0, 0);
            @(negedge clk);
            check("R8", "done one cycle", int'(done_o), 0);
            check("R8", "busy low after done", int'(busy_o), 0);
        end
    endtask

    task automatic t_reset;
        check("R1", "busy after reset", int'(busy_o), 0);
        check("R1", "rd_req after reset", int'(rd_req_o), 0);
        check("R1", "done after reset", int'(done_o), 0);
        repeat (3) @(negedge clk);
        check("R1", "no read while idle", nreads, 0);
    endtask

    task automatic t_program_loop;
        // R4 two misses with bit5=0, R3 match then distinct confirm byte
        scr[0] = 8'h05; scr[1] = 8'h45; scr[2] = 8'hB1; scr[3] = 8'hA5;
        run_op("R3", 1'b0, 20'h1234A, 8'hA5, 10, -1, 1, 0, 8'hA5, 4);
    endtask

    task automatic t_recheck_pass;
        scr[0] = 8'h80; scr[1] = 8'hA0; scr[2] = 8'h3C; scr[3] = 8'h3D;
        run_op("R5", 1'b0, 20'h00777, 8'h3C, 10, -1, 1, 0, 8'h3D, 4);
    endtask

    task automatic t_recheck_fail;
        scr[0] = 8'hA0; scr[1] = 8'hA4; scr[2] = 8'h00;
        run_op("R5", 1'b0, 20'hF0F0F, 8'h00, 10, -1, 0, 0, 8'hA4, 2);
    endtask

    task automatic t_erase;
        // R6 data_i bit7=0 but erase expects 1
        scr[0] = 8'h00; scr[1] = 8'h7F; scr[2] = 8'hFF; scr[3] = 8'hFF;
        run_op("R6", 1'b1, 20'h40000, 8'h00, 10, -1, 1, 0, 8'hFF, 4);
    endtask

    task automatic t_program_b7_zero;
        // R6 program with expected bit7=0: first read 0x12 matches
        scr[0] = 8'h12; scr[1] = 8'h34;
        run_op("R6", 1'b0, 20'h00010, 8'h34, 10, -1, 1, 0, 8'h34, 2);
    endtask

    task automatic t_timeout;
        for (int i = 0; i < 16; i++) scr[i] = 8'h01;
        run_op("R7", 1'b0, 20'h00100, 8'h80, 3, -1, 0, 1, 8'h01, 3);
    endtask

    task automatic t_timeout_zero;
        for (int i = 0; i < 16; i++) scr[i] = 8'h02;
        run_op("R7", 1'b0, 20'h00200, 8'h80, 0, -1, 0, 1, 8'h02, 1);
    endtask

    task automatic t_start_busy;
        for (int i = 0; i < 16; i++) scr[i] = 8'h00;
        scr[5] = 8'h80; scr[6] = 8'h81;
        run_op("R9", 1'b0, 20'h0ABCD, 8'h80, 10, 4, 1, 0, 8'h81, 7);
        repeat (4) @(negedge clk);
        check("R9", "no restart from ignored start", int'(busy_o), 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) scr[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_program_loop();
        t_recheck_pass();
        t_recheck_fail();
        t_erase();
        t_program_b7_zero();
        t_timeout();
        t_timeout_zero();
        t_start_busy();
        check("R10", "one read per ack overall", nreads, 27);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule